// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block holds a protection register of `NUM_WORDS` words of `WORD_W` bits each. The default is eight 16-bit words, 128 bits in all. The lower half of the words is a factory identifier. It is fixed by the `FACTORY_ID` parameter, is visible from power-on, and can never be altered. The upper half is a user area that is one-time-programmable. Every bit starts erased at 1, and a program operation can only pull bits down to 0.

Two further one-time bits give permanent protection. The user-protect bit freezes the user half once it is cleared. The security-protect bit, once cleared, tells the surrounding memory that its security block may no longer be programmed or erased.

Requests arrive on one word-wide port. A request is a valid strobe, a 2-bit operation code, a word index and write data. Read data and error pulses come back one clock later. Only the power-on reset `por_n` restores the user words and the protect bits. The synchronous soft reset `soft_rst_n` clears only the response outputs, so the one-time state survives it.

Top module: `otp_prot_reg`

## Requirements
- R1: After power-on reset, a read of word index i below NUM_WORDS/2 returns FACTORY_ID bits [WORD_W*i+WORD_W-1 : WORD_W*i], and this value never changes.
- R2: After power-on reset, every user word (index NUM_WORDS/2 and above) reads as all ones, and `user_locked` and `sec_locked` are both 0.
- R3: A read request (op 2'b00) accepted at a clock edge drives `rd_valid` high with the addressed word on `rd_data` for exactly the following cycle. `rd_valid` is low after any other operation.
- R4: A program request (op 2'b01) to an unlocked user word sets that word to the old value AND `req_wdata`, so bits only move from 1 to 0.
- R5: A program request to a factory word leaves the register unchanged, and `wr_err` is high for the cycle after it.
- R6: A lock-user request (op 2'b10) sets `user_locked` permanently. From then on every program to a user word leaves the data unchanged and raises `wr_err` for one cycle.
- R7: A lock-security request (op 2'b11) sets `sec_locked` permanently, and it stays set through soft resets.
- R8: While `soft_rst_n` is low, requests are ignored. `rd_valid` and `wr_err` go low, and user data and protect bits keep their values.
- R9: `wr_err` stays low after reads, lock requests and permitted programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; restores the erased OTP state |
| soft_rst_n | input | 1 | Synchronous soft reset, active low; clears only the response outputs |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 read, 01 program, 10 lock user half, 11 lock security block |
| req_addr | input | ADDR_W (3) | Word index |
| req_wdata | input | WORD_W (16) | Program data; each 0 bit clears the matching stored bit |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | WORD_W (16) | Read response word |
| wr_err | output | 1 | One-cycle pulse for a refused program |
| user_locked | output | 1 | User half permanently frozen |
| sec_locked | output | 1 | Security block permanently protected against program and erase |

## Verification
The bench builds the block with its default geometry of eight 16-bit words and a non-symmetric `FACTORY_ID` value, so every factory word is different. That makes a swapped or misindexed factory read visible. With only four user words, random programs hit each word many times, and the AND accumulation drives words down to zero. Both lock bits are reached within a short run, and so are soft resets before and after locking.

// File: rtl/otp_pkg.sv
package otp_pkg;
   typedef enum logic [1:0] {
      OP_READ      = 2'b00,
      OP_PROG      = 2'b01,
      OP_LOCK_USER = 2'b10,
      OP_LOCK_SEC  = 2'b11
   } otp_op_e;
endpackage

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl
   import otp_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   localparam int ADDR_W = $clog2(NUM_WORDS),
   localparam int HALF = NUM_WORDS / 2
) (
   input  logic              soft_rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              user_locked,
   output logic              prog_en,
   output logic              err_set,
   output logic              rd_take,
   output logic              lock_user_set,
   output logic              lock_sec_set
);
   logic    live;
   logic    in_user;
   otp_op_e op;

   always_comb begin
      op            = otp_op_e'(req_op);
      live          = req_valid & soft_rst_n;
      in_user       = (int'(req_addr) >= HALF);
      rd_take       = live & (op == OP_READ);
      prog_en       = live & (op == OP_PROG) & in_user & ~user_locked;
      err_set       = live & (op == OP_PROG) & (~in_user | user_locked);
      lock_user_set = live & (op == OP_LOCK_USER);
      lock_sec_set  = live & (op == OP_LOCK_SEC);
   end
endmodule

// File: rtl/otp_user_array.sv
module otp_user_array #(
   parameter int WORD_W = 16,
   parameter int USER_WORDS = 4,
   localparam int IDX_W = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              prog_en,
   input  logic [IDX_W-1:0]  prog_idx,
   input  logic [WORD_W-1:0] prog_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] cells [USER_WORDS];

   for (genvar w = 0; w < USER_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            cells[w] <= '1;
         else if (prog_en && (int'(prog_idx) == w))
            cells[w] <= cells[w] & prog_data;
      end
   end

   assign rd_word = cells[rd_idx];
endmodule

// File: rtl/otp_lock_bits.sv
module otp_lock_bits (
   input  logic clk,
   input  logic por_n,
   input  logic clr_user,
   input  logic clr_sec,
   output logic user_locked,
   output logic sec_locked
);
   logic user_open_n;
   logic sec_open_n;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         user_open_n <= 1'b1;
         sec_open_n  <= 1'b1;
      end else begin
         if (clr_user) user_open_n <= 1'b0;
         if (clr_sec)  sec_open_n  <= 1'b0;
      end
   end

   assign user_locked = ~user_open_n;
   assign sec_locked  = ~sec_open_n;
endmodule

// File: rtl/otp_prot_reg.sv
module otp_prot_reg #(
   parameter int WORD_W = 16,
   parameter int NUM_WORDS = 8,
   parameter logic [WORD_W*NUM_WORDS/2-1:0] FACTORY_ID = 64'h3C5A_96E1_0B7D_F248,
   localparam int ADDR_W = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              soft_rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              wr_err,
   output logic              user_locked,
   output logic              sec_locked
);
   localparam int HALF  = NUM_WORDS / 2;
   localparam int UIDX_W = ADDR_W - 1;

   if (NUM_WORDS < 4 || (1 << ADDR_W) != NUM_WORDS) begin : g_bad_words
      $error("NUM_WORDS must be a power of two, at least 4");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("WORD_W must be positive");
   end

   logic              prog_en, err_set, rd_take, lock_user_set, lock_sec_set;
   logic [WORD_W-1:0] user_word;
   logic [WORD_W-1:0] fact_words [HALF];
   logic [WORD_W-1:0] sel_word;

   for (genvar f = 0; f < HALF; f++) begin : g_fact
      assign fact_words[f] = FACTORY_ID[f*WORD_W +: WORD_W];
   end

   otp_access_ctrl #(.NUM_WORDS(NUM_WORDS)) ctrl_i (
      .soft_rst_n   (soft_rst_n),
      .req_valid    (req_valid),
      .req_op       (req_op),
      .req_addr     (req_addr),
      .user_locked  (user_locked),
      .prog_en      (prog_en),
      .err_set      (err_set),
      .rd_take      (rd_take),
      .lock_user_set(lock_user_set),
      .lock_sec_set (lock_sec_set)
   );

   otp_user_array #(.WORD_W(WORD_W), .USER_WORDS(HALF)) user_i (
      .clk      (clk),
      .por_n    (por_n),
      .prog_en  (prog_en),
      .prog_idx (req_addr[UIDX_W-1:0]),
      .prog_data(req_wdata),
      .rd_idx   (req_addr[UIDX_W-1:0]),
      .rd_word  (user_word)
   );

   otp_lock_bits locks_i (
      .clk        (clk),
      .por_n      (por_n),
      .clr_user   (lock_user_set),
      .clr_sec    (lock_sec_set),
      .user_locked(user_locked),
      .sec_locked (sec_locked)
   );

   assign sel_word = req_addr[ADDR_W-1] ? user_word : fact_words[req_addr[UIDX_W-1:0]];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         wr_err   <= 1'b0;
      end else if (!soft_rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         wr_err   <= 1'b0;
      end else begin
         rd_valid <= rd_take;
         wr_err   <= err_set;
         if (rd_take) rd_data <= sel_word;
      end
   end
endmodule

// File: rtl/otp_prot_reg_chk.sv
module otp_prot_reg_chk #(
   parameter int NUM_WORDS = 8,
   localparam int ADDR_W = $clog2(NUM_WORDS)
) (
   input logic              clk,
   input logic              por_n,
   input logic              soft_rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rd_valid,
   input logic              wr_err,
   input logic              user_locked,
   input logic              sec_locked
);
   assert_rd_resp_R3: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst_n && req_valid && req_op == 2'b00) |=> rd_valid);

   assert_fact_err_R5: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst_n && req_valid && req_op == 2'b01 && !req_addr[ADDR_W-1]) |=> wr_err);

   assert_user_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
      user_locked |=> user_locked);

   assert_locked_err_R6: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst_n && req_valid && req_op == 2'b01 && user_locked) |=> wr_err);

   assert_sec_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
      sec_locked |=> sec_locked);

   assert_soft_quiet_R8: assert property (@(posedge clk) disable iff (!por_n)
      !soft_rst_n |=> (!rd_valid && !wr_err));

   assert_no_err_read_R9: assert property (@(posedge clk) disable iff (!por_n)
      (soft_rst_n && req_valid && req_op != 2'b01) |=> !wr_err);
endmodule

bind otp_prot_reg otp_prot_reg_chk #(.NUM_WORDS(NUM_WORDS)) chk_i (
   .clk        (clk),
   .por_n      (por_n),
   .soft_rst_n (soft_rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .req_addr   (req_addr),
   .rd_valid   (rd_valid),
   .wr_err     (wr_err),
   .user_locked(user_locked),
   .sec_locked (sec_locked)
);

// File: tb/otp_prot_reg_tb.sv
module otp_prot_reg_tb_top;
   localparam int WW = 16;
   localparam int NW = 8;
   localparam int AW = 3;
   localparam logic [63:0] ID = 64'h1234_5678_9ABC_DEF0;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          soft_rst_n = 1'b1;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [WW-1:0] req_wdata = '0;
   logic          rd_valid, wr_err, user_locked, sec_locked;
   logic [WW-1:0] rd_data;

   int checks = 0;
   int fails = 0;
   logic [WW-1:0] exp_user [4];
   logic exp_ul = 1'b0;
   logic exp_sl = 1'b0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   otp_prot_reg #(.WORD_W(WW), .NUM_WORDS(NW), .FACTORY_ID(ID)) dut_i (
      .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .req_valid(req_valid),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .wr_err(wr_err),
      .user_locked(user_locked), .sec_locked(sec_locked)
   );

   function automatic logic [WW-1:0] exp_word(input int a);
      if (a < 4) return ID[a*WW +: WW];
      return exp_user[a-4];
   endfunction

   task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] op, input int a, input logic [WW-1:0] d, input string tag);
      logic e_err;
      logic e_rv;
      logic [WW-1:0] e_rd;
      bit live;
      live  = soft_rst_n;
      e_rv  = live && (op == 2'b00);
      e_rd  = exp_word(a);
      e_err = live && (op == 2'b01) && (a < 4 || exp_ul);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_wdata = d;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      if (live) begin
         if (op == 2'b01 && a >= 4 && !exp_ul) exp_user[a-4] = exp_user[a-4] & d;
         if (op == 2'b10) exp_ul = 1'b1;
         if (op == 2'b11) exp_sl = 1'b1;
      end
      check({tag, " rd_valid"}, WW'(rd_valid), WW'(e_rv));
      check({tag, " wr_err"}, WW'(wr_err), WW'(e_err));
      if (e_rv) check({tag, " rd_data"}, rd_data, e_rd);
      check({tag, " locks"}, WW'({user_locked, sec_locked}), WW'({exp_ul, exp_sl}));
   endtask

   task automatic read_all(input string tag);
      for (int a = 0; a < NW; a++) do_op(2'b00, a, '0, tag);
   endtask

   task automatic random_ops(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         int a;
         logic [1:0] op;
         logic [WW-1:0] d;
         a  = int'($urandom_range(NW-1, 0));
         op = ($urandom_range(1, 0) == 0) ? 2'b00 : 2'b01;
         d  = WW'($urandom) | WW'($urandom);
         do_op(op, a, d, tag);
      end
   endtask

   initial begin
      #500000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 4; i++) exp_user[i] = '1;
      repeat (3) @(posedge clk);
      #1;
      // R2: reset state of outputs
      check("R2 reset outputs", WW'({rd_valid, wr_err, user_locked, sec_locked}), '0);
      @(negedge clk);
      por_n = 1'b1;
      // R1 R2 R3: factory and erased user words
      read_all("R1 R2 R3 initial read");
      // R5: program factory word refused
      do_op(2'b01, 2, 16'h0000, "R5 factory program");
      do_op(2'b00, 2, '0, "R5 factory unchanged");
      // R4: AND accumulation
      do_op(2'b01, 5, 16'hFF00, "R4 R9 program 1");
      do_op(2'b01, 5, 16'h0FFF, "R4 R9 program 2");
      do_op(2'b00, 5, '0, "R4 accumulated");
      do_op(2'b01, 6, 16'hFFFF, "R4 all ones no-op");
      do_op(2'b00, 6, '0, "R4 all ones read");
      random_ops(400, "R4 R5 R9 random");
      // R8: soft reset ignores requests, keeps data
      @(negedge clk);
      soft_rst_n = 1'b0;
      do_op(2'b01, 7, 16'h0000, "R8 program in soft reset");
      do_op(2'b10, 0, '0, "R8 lock in soft reset");
      do_op(2'b00, 7, '0, "R8 read in soft reset");
      @(negedge clk);
      soft_rst_n = 1'b1;
      read_all("R8 after soft reset");
      // R6: lock the user half
      do_op(2'b10, 0, '0, "R6 R9 lock user");
      do_op(2'b01, 4, 16'h0000, "R6 locked program");
      do_op(2'b00, 4, '0, "R6 locked unchanged");
      random_ops(200, "R1 R6 random locked");
      // R7: lock security block, survives soft reset
      do_op(2'b11, 3, '0, "R7 R9 lock sec");
      do_op(2'b11, 1, '0, "R7 relock");
      @(negedge clk);
      soft_rst_n = 1'b0;
      do_op(2'b00, 0, '0, "R7 R8 soft reset hold");
      @(negedge clk);
      soft_rst_n = 1'b1;
      read_all("R1 R7 final read");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule